// File: doc/BRIEF.md
# Addressed Transmit Pipe Endpoint

This block is one addressable endpoint on a shared host-side bus. It moves bytes from user logic toward the host. A start command on the broadcast side names a 7-bit endpoint address and a byte count. The endpoint whose address matches raises a write-request strobe to user logic. The user logic then presents one byte on every clock edge while the strobe is high. Each byte that is taken goes out on a 10-bit return bus. Return buses from many endpoints are OR-combined, so an endpoint that has nothing to send drives all zeros.

The endpoint keeps its own count of the downstream buffer occupancy, which holds 2048 bytes. Each captured byte adds one entry. An addressed drain pulse from the host side removes one entry. The strobe is withheld whenever one more byte would not fit. User logic can also hold the transfer with a pause input. After pause rises, the endpoint still takes exactly one more byte, and it resumes on the edge after pause falls.

Top module: `ep_tx_pipe`

## Requirements
- R1: After reset, wr_req_o is low and ret_o is all zeros.
- R2: A start pulse whose bus address equals ep_addr_i, carrying a non-zero length, sets wr_req_o high in the cycle after that edge. A start pulse to any other address leaves wr_req_o low and ret_o zero.
- R3: On every edge where wr_req_o was high, data_i is captured. In the next cycle ret_o carries bit 9 = 1 (valid) and bits 7:0 = the captured byte.
- R4: Exactly the requested number of bytes is captured. Bit 8 of ret_o marks the final byte, and wr_req_o is low from that cycle on. A start with length 0 never raises wr_req_o.
- R5: Occupancy rises by one per captured byte. It falls by one for each drain pulse addressed to this endpoint while occupancy is non-zero. wr_req_o is low whenever occupancy has reached 2048. A drain pulse to another address has no effect.
- R6: The byte presented at the edge where pause_i is first sampled high is still captured. No further byte is captured while pause_i stays high. wr_req_o is high in the cycle after the edge where pause_i is sampled low again.
- R7: If pause_i is high when the start pulse arrives, wr_req_o stays low until pause_i is released.
- R8: In every cycle that does not follow a capture, ret_o is all zeros.
- R9: A start pulse that arrives while a transfer is still outstanding is ignored, and the original length stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_addr_i | input | 7 | Address of this endpoint |
| bus_addr_i | input | 7 | Address carried by the broadcast bus |
| bus_start_i | input | 1 | Start-of-transfer command pulse |
| bus_len_i | input | 16 | Byte count for a start command |
| bus_drain_i | input | 1 | Host removed one byte from the downstream buffer |
| pause_i | input | 1 | User request to hold the transfer |
| data_i | input | 8 | User byte |
| wr_req_o | output | 1 | Write-request strobe to user logic |
| ret_o | output | 10 | Return bus: bit 9 valid, bit 8 last, bits 7:0 data |

## Verification
The assertions check, on every cycle, the properties that relate neighbouring cycles. A strobe is always followed by a valid return word that carries the sampled byte. A cycle without a strobe is always followed by a zero return word. A sampled pause always clears the strobe. The strobe is never high at full occupancy or after the last byte, and occupancy never passes 2048. Other behaviour spans many cycles, and only the bench scenarios show it: the exact byte total per transfer, the ignored second start, the ignored foreign-address drain, and the one-byte skid followed by a resume.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
  localparam int DATA_W = 8;
  localparam int RET_W  = DATA_W + 2;

  typedef struct packed {
    logic              vld;
    logic              last;
    logic [DATA_W-1:0] data;
  } ret_word_t;
endpackage

// File: rtl/ep_tx_decode.sv
module ep_tx_decode #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] ep_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_start_i,
  input  logic              bus_drain_i,
  output logic              start_hit_o,
  output logic              drain_hit_o
);
  logic match;

  assign match       = (bus_addr_i == ep_addr_i);
  assign start_hit_o = bus_start_i & match;
  assign drain_hit_o = bus_drain_i & match;
endmodule

// File: rtl/ep_tx_fill.sv
module ep_tx_fill #(
  parameter int BUF_DEPTH = 2048,
  parameter int FILL_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              drain_i,
  output logic [FILL_W-1:0] fill_o,
  output logic              room_next_o
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(BUF_DEPTH);

  logic [FILL_W-1:0] fill_q, fill_d;
  logic              drain_ok;

  assign drain_ok = drain_i && (fill_q != '0);

  always_comb begin
    fill_d = fill_q + FILL_W'(push_i) - FILL_W'(drain_ok);
  end

  // room for one more byte after this edge
  assign room_next_o = (fill_d < FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= fill_d;
  end

  assign fill_o = fill_q;
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_hit_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pause_i,
  input  logic             room_next_i,
  output logic             req_o,
  output logic             cap_o,
  output logic             last_o,
  output logic [LEN_W-1:0] rem_o
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             req_q, req_d;
  logic             start_ok;

  assign start_ok = start_hit_i && (rem_q == '0);

  always_comb begin
    if (start_ok) rem_d = len_i;
    else          rem_d = rem_q - LEN_W'(req_q);
    req_d = (rem_d != '0) && room_next_i && !pause_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      req_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      req_q <= req_d;
    end
  end

  assign req_o  = req_q;
  assign cap_o  = req_q;
  assign last_o = (rem_q == LEN_W'(1));
  assign rem_o  = rem_q;
endmodule

// File: rtl/ep_tx_ret.sv
module ep_tx_ret
  import ep_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [RET_W-1:0]  ret_o
);
  ret_word_t ret_q, ret_d;

  always_comb begin
    ret_d = '0;
    if (cap_i) begin
      ret_d.vld  = 1'b1;
      ret_d.last = last_i;
      ret_d.data = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ret_q <= '0;
    else         ret_q <= ret_d;
  end

  assign ret_o = ret_q;
endmodule

// File: rtl/ep_tx_pipe.sv
module ep_tx_pipe
  import ep_tx_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int LEN_W     = 16,
  parameter int BUF_DEPTH = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ep_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_start_i,
  input  logic [LEN_W-1:0]  bus_len_i,
  input  logic              bus_drain_i,
  input  logic              pause_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_req_o,
  output logic [RET_W-1:0]  ret_o
);
  localparam int FILL_W = $clog2(BUF_DEPTH + 1);

  logic              start_hit, drain_hit;
  logic              room_next, cap, last;
  logic [FILL_W-1:0] fill_w;
  logic [LEN_W-1:0]  rem_w;

  ep_tx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ep_addr_i   (ep_addr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_start_i (bus_start_i),
    .bus_drain_i (bus_drain_i),
    .start_hit_o (start_hit),
    .drain_hit_o (drain_hit)
  );

  ep_tx_fill #(.BUF_DEPTH(BUF_DEPTH), .FILL_W(FILL_W)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (cap),
    .drain_i     (drain_hit),
    .fill_o      (fill_w),
    .room_next_o (room_next)
  );

  ep_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_hit_i (start_hit),
    .len_i       (bus_len_i),
    .pause_i     (pause_i),
    .room_next_i (room_next),
    .req_o       (wr_req_o),
    .cap_o       (cap),
    .last_o      (last),
    .rem_o       (rem_w)
  );

  ep_tx_ret u_ret (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .last_i (last),
    .data_i (data_i),
    .ret_o  (ret_o)
  );
endmodule

// File: rtl/ep_tx_pipe_chk.sv
module ep_tx_pipe_chk #(
  parameter int LEN_W     = 16,
  parameter int BUF_DEPTH = 2048,
  parameter int FILL_W    = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pause_i,
  input logic [7:0]        data_i,
  input logic              wr_req_o,
  input logic [9:0]        ret_o,
  input logic [FILL_W-1:0] fill_i,
  input logic [LEN_W-1:0]  rem_i,
  input logic              start_hit_i
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(BUF_DEPTH);

  a_r3_capture_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |=> (ret_o[9] && ret_o[7:0] == $past(data_i)));

  a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_o |=> (ret_o == '0));

  a_r6_pause_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> !wr_req_o);

  a_r5_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == FULL) |-> !wr_req_o);

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FULL);

  a_r4_last_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o[8] |-> !wr_req_o);

  a_r2_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_i == '0 && !start_hit_i) |=> !wr_req_o);
endmodule

bind ep_tx_pipe ep_tx_pipe_chk #(
  .LEN_W(LEN_W), .BUF_DEPTH(BUF_DEPTH), .FILL_W(FILL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pause_i     (pause_i),
  .data_i      (data_i),
  .wr_req_o    (wr_req_o),
  .ret_o       (ret_o),
  .fill_i      (fill_w),
  .rem_i       (rem_w),
  .start_hit_i (start_hit)
);

// File: tb/tb_ep_tx_pipe.sv
`timescale 1ns/1ps
module tb_ep_tx_pipe;
  localparam logic [6:0] EP = 7'h2A;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_start = 1'b0;
  logic [15:0] bus_len = '0;
  logic       bus_drain = 1'b0;
  logic       pause = 1'b0;
  logic [7:0] data = '0;
  logic       wr_req;
  logic [9:0] ret;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  string tag = "R1";

  int         m_rem = 0;
  int         m_fill = 0;
  bit         m_req = 1'b0;
  logic [9:0] m_ret = '0;

  always #2.5 clk = ~clk;

  ep_tx_pipe dut (
    .clk_i(clk), .rst_ni(rst_n), .ep_addr_i(EP), .bus_addr_i(bus_addr),
    .bus_start_i(bus_start), .bus_len_i(bus_len), .bus_drain_i(bus_drain),
    .pause_i(pause), .data_i(data), .wr_req_o(wr_req), .ret_o(ret)
  );

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // reference model, updated from the requirements at each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_fill = 0; m_req = 0; m_ret = '0;
    end else begin
      bit cap, drn, st;
      cap = m_req;
      m_ret = cap ? {1'b1, (m_rem == 1), data} : 10'h0;
      drn = bus_drain && (bus_addr == EP) && (m_fill > 0);
      st  = bus_start && (bus_addr == EP) && (m_rem == 0);
      m_rem  = st ? int'(bus_len) : m_rem - int'(cap);
      m_fill = m_fill + int'(cap) - int'(drn);
      m_req  = (m_rem > 0) && (m_fill < DEPTH) && !pause;
    end
  end

  always @(negedge clk) begin
    chk(wr_req === m_req, tag, "wr_req", int'(wr_req), int'(m_req));
    chk(ret === m_ret, tag, "ret", int'(ret), int'(m_ret));
    if (ret[9] === 1'b1) delivered++;
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
      data = 8'($urandom);
      bus_start = 1'b0;
      bus_drain = 1'b0;
    end
  endtask

  task automatic start(input logic [6:0] a, input int len);
    @(negedge clk); #0.5;
    data = 8'($urandom);
    bus_drain = 1'b0;
    bus_addr = a; bus_len = 16'(len); bus_start = 1'b1;
    tick(1);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired tag=%s actual=1 expected=0", tag);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    chk(wr_req === 1'b0, "R1", "req in reset", int'(wr_req), 0);
    chk(ret === 10'h0, "R1", "ret in reset", int'(ret), 0);
    #0.5 rst_n = 1'b1;
    tick(2);

    tag = "R2"; delivered = 0;
    start(7'h11, 4);
    tick(6);
    chk(delivered == 0, "R2", "bytes for foreign address", delivered, 0);

    tag = "R3"; delivered = 0;
    start(EP, 5);
    chk(wr_req === 1'b1, "R2", "req after matching start", int'(wr_req), 1);
    tick(8);
    chk(delivered == 5, "R4", "bytes delivered", delivered, 5);

    tag = "R4"; delivered = 0;
    start(EP, 0);
    tick(4);
    chk(delivered == 0, "R4", "zero length bytes", delivered, 0);

    tag = "R6"; delivered = 0;
    start(EP, 6);
    tick(1);
    @(negedge clk); #0.5 pause = 1'b1; data = 8'($urandom);
    tick(3);
    chk(wr_req === 1'b0, "R6", "req while paused", int'(wr_req), 0);
    chk(delivered == 3, "R6", "bytes incl skid", delivered, 3);
    @(negedge clk); #0.5 pause = 1'b0; data = 8'($urandom);
    tick(1);
    chk(wr_req === 1'b1, "R6", "req after release", int'(wr_req), 1);
    tick(6);
    chk(delivered == 6, "R6", "total after pause", delivered, 6);

    tag = "R7"; delivered = 0;
    @(negedge clk); #0.5 pause = 1'b1;
    start(EP, 3);
    tick(4);
    chk(wr_req === 1'b0, "R7", "req with early pause", int'(wr_req), 0);
    @(negedge clk); #0.5 pause = 1'b0;
    tick(6);
    chk(delivered == 3, "R7", "bytes after early pause", delivered, 3);

    tag = "R9"; delivered = 0;
    start(EP, 3);
    start(EP, 10);
    tick(14);
    chk(delivered == 3, "R9", "second start ignored", delivered, 3);

    tag = "R5"; delivered = 0;
    start(EP, DEPTH + 40 - m_fill);
    tick(DEPTH + 20);
    chk(wr_req === 1'b0, "R5", "req at full", int'(wr_req), 0);
    chk(m_fill == DEPTH, "R5", "model occupancy", m_fill, DEPTH);
    @(negedge clk); #0.5 bus_addr = 7'h05; bus_drain = 1'b1;
    tick(3);
    chk(wr_req === 1'b0, "R5", "foreign drain ignored", int'(wr_req), 0);
    @(negedge clk); #0.5 bus_addr = EP; bus_drain = 1'b1;
    tick(1);
    chk(wr_req === 1'b1, "R5", "req after drain", int'(wr_req), 1);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); #0.5 bus_addr = EP; bus_drain = 1'b1; data = 8'($urandom);
    end
    tick(4);
    chk(wr_req === 1'b0, "R8", "idle after transfer", int'(wr_req), 0);
    chk(ret === 10'h0, "R8", "ret zero when idle", int'(ret), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule